// File: doc/BRIEF.md
# I2C Target Register-Access Engine

This block is an I2C bus target that gives a host byte access to an internal register space at locations 0x00 through 0x6B. It oversamples SCL and SDA with a fast system clock. It never drives either line high: it only asserts pull-down enables toward open-drain pads. A single byte pointer selects the location for every access. A write transaction loads the pointer from its first byte after the address and stores each following byte at the pointer. A read transaction either starts at the pointer as it stands (a quick read) or follows a command byte and a repeated start.

The pointer moves forward by one whenever a data byte is acknowledged, whichever side gives the acknowledge. It keeps its value across STOP, so quick reads continue where the last access ended. Register storage sits outside the block and is reached through a plain address / write-data / write-strobe / read-data port. A per-location mask marks locations as read-only. A watchdog on each bus line frees the bus if either line stays low for too long, and it flags a fault if something external keeps the line low.

Top module: `i2cRegTarget`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x55 (byte 0xAA to write, 0xAB to read). For any other address it drives SDA for none of that transaction's bytes and writes nothing until the next START.
- R2: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer location with a one-cycle regWrEn pulse and is acknowledged, so one transaction fills consecutive locations.
- R3: A command byte, a repeated start and the read address return data starting at the command's location. Successive bytes come from consecutive locations until the host answers a byte with NACK and then STOP.
- R4: A read with no command byte returns data starting at the current pointer. The pointer survives STOP and is 0x00 after reset.
- R5: The pointer advances by one on each acknowledged data byte, in a write (target ACK) and in a read (host ACK). A host NACK leaves it unchanged.
- R6: A command byte above 0x6B gets a NACK and leaves the pointer unchanged. The target then acknowledges nothing and writes nothing until the next START.
- R7: A data byte aimed at a location whose roMask bit is 1 gets a NACK, is not stored and leaves the pointer unchanged. The rest of that transaction is ignored.
- R8: Read data goes out MSB first, and each bit is on SDA before the next SCL rising edge. A byte read from a pointer above 0x6B reads as 0xFF. A write at such a pointer is NACKed.
- R9: If SCL or SDA stays low for TIMEOUT_CYC system clocks without a break, the target releases SDA and returns to idle. If a line is still low FAULT_GRACE clocks later, busFault is 1 until that line goes high.
- R10: sdaPullDn becomes active only while SCL is low. sclPullDn is always 0. After reset neither line is driven and busFault is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| sclPullDn | output | 1 | SCL pull-down enable (held inactive) |
| sdaPullDn | output | 1 | SDA pull-down enable |
| regAddr | output | 8 | Register location, equal to the pointer |
| regWrData | output | 8 | Byte to store |
| regWrEn | output | 1 | Store strobe, one clock per written byte |
| regRdData | input | 8 | Contents of location regAddr |
| roMask | input | LAST_REG+1 | Bit n set makes location n read-only |
| busFault | output | 1 | A line is stuck low after the timeout release |

## Verification
The main pattern is a sweep that writes every location in one long write transaction and then reads all of them back in one read. Each value is a different arithmetic function of its index, so a pointer that skips or repeats a location shows up as a mismatch. Short writes, command-plus-restart reads and quick reads each end with a different ACK/NACK pattern. These tell apart a pointer that advances on host ACK from one that advances on host NACK, and show whether the pointer survives STOP. Wrong addresses, out-of-range commands and read-only targets are each followed by a quick read, which exposes any pointer change they cause. Two stuck-bus cases separate a line the target itself holds, which gets released, from a line held by the host, which raises busFault.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_IGNORE
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic loadPtr;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic setAck;
    logic clrAck;
    logic wrStrobe;
    logic txEn;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic timeoutEv;
    logic byteDone;
    logic addrMatch;
    logic rwBit;
    logic cmdOk;
    logic ptrWritable;
    logic sdaBit;
  } dpStatus_t;

endpackage

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h55,
  parameter int         LAST_REG    = 107,
  parameter int         TIMEOUT_CYC = 4096,
  parameter int         FAULT_GRACE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  ctlStrobe_t          ctl,
  input  logic [LAST_REG:0]   roMask,
  input  logic [7:0]          regRdData,
  output dpStatus_t           st,
  output logic [7:0]          regAddr,
  output logic [7:0]          regWrData,
  output logic                regWrEn,
  output logic                sdaPullDn,
  output logic                busFault
);
  localparam int         NUM_REGS  = LAST_REG + 1;
  localparam int         IDXW      = $clog2(NUM_REGS);
  localparam int         FAULT_CYC = TIMEOUT_CYC + FAULT_GRACE;
  localparam int         TOW       = $clog2(FAULT_CYC + 1);
  localparam logic [7:0] LAST_PTR  = 8'(LAST_REG);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift, ptr, rdByte;
  logic       ackDrive;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  // bit counter, receive shifter, transmit shifter, pointer, ack drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '1;
      ptr      <= '0;
      ackDrive <= 1'b0;
    end else begin
      if (ctl.clrCnt)                        bitCnt <= '0;
      else if (st.sclRise && !st.byteDone)   bitCnt <= bitCnt + 4'd1;
      if (st.sclRise)                        rxShift <= {rxShift[6:0], sdaS};
      if (ctl.loadTx)                        txShift <= rdByte;
      else if (ctl.shiftTx)                  txShift <= {txShift[6:0], 1'b1};
      if (ctl.loadPtr)                       ptr <= rxShift;
      else if (ctl.incPtr)                   ptr <= ptr + 8'd1;
      if (ctl.clrAck)                        ackDrive <= 1'b0;
      else if (ctl.setAck)                   ackDrive <= 1'b1;
    end
  end

  assign rdByte = (ptr <= LAST_PTR) ? regRdData : 8'hFF;

  always_comb begin
    if (ptr <= LAST_PTR) st.ptrWritable = ~roMask[ptr[IDXW-1:0]];
    else                 st.ptrWritable = 1'b0;
  end

  assign st.sclRise   = sclS & ~sclPrev;
  assign st.sclFall   = ~sclS & sclPrev;
  assign st.startEv   = sclS & sclPrev & sdaPrev & ~sdaS;
  assign st.stopEv    = sclS & sclPrev & ~sdaPrev & sdaS;
  assign st.byteDone  = (bitCnt == 4'd8);
  assign st.addrMatch = (rxShift[7:1] == TGT_ADDR);
  assign st.rwBit     = rxShift[0];
  assign st.cmdOk     = (rxShift <= LAST_PTR);
  assign st.sdaBit    = sdaS;

  // one low-time watchdog per line
  logic [1:0] lineHigh, hitTimeout, hitFault;
  assign lineHigh = {sclS, sdaS};

  for (genvar g = 0; g < 2; g++) begin : gLineTimer
    logic [TOW-1:0] lowCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            lowCnt <= '0;
      else if (lineHigh[g])                 lowCnt <= '0;
      else if (lowCnt != TOW'(FAULT_CYC))   lowCnt <= lowCnt + 1'b1;
    end
    assign hitTimeout[g] = (lowCnt == TOW'(TIMEOUT_CYC));
    assign hitFault[g]   = (lowCnt == TOW'(FAULT_CYC));
  end

  assign st.timeoutEv = |hitTimeout;
  assign busFault     = |hitFault;

  assign regAddr   = ptr;
  assign regWrData = rxShift;
  assign regWrEn   = ctl.wrStrobe;
  assign sdaPullDn = ackDrive | (ctl.txEn & ~txShift[7]);

endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl
);
  tgtState_e state, nxt;
  logic      rwFlag, hostAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rwFlag  <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_ADDR && st.sclFall && st.byteDone) rwFlag  <= st.rwBit;
      if (state == ST_RD_ACK && st.sclRise)              hostAck <= ~st.sdaBit;
    end
  end

  always_comb begin
    ctl      = '0;
    nxt      = state;
    ctl.txEn = (state == ST_RD);
    if (st.timeoutEv || st.stopEv) begin
      nxt        = ST_IDLE;
      ctl.clrAck = 1'b1;
    end else if (st.startEv) begin
      nxt        = ST_ADDR;
      ctl.clrCnt = 1'b1;
      ctl.clrAck = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: if (st.sclFall && st.byteDone) begin
          ctl.clrCnt = 1'b1;
          if (st.addrMatch) begin
            ctl.setAck = 1'b1;
            nxt        = ST_ADDR_ACK;
          end else nxt = ST_IGNORE;
        end
        ST_ADDR_ACK: if (st.sclFall) begin
          ctl.clrAck = 1'b1;
          ctl.clrCnt = 1'b1;
          if (rwFlag) begin
            ctl.loadTx = 1'b1;
            nxt        = ST_RD;
          end else nxt = ST_CMD;
        end
        ST_CMD: if (st.sclFall && st.byteDone) begin
          ctl.clrCnt = 1'b1;
          if (st.cmdOk) begin
            ctl.loadPtr = 1'b1;
            ctl.setAck  = 1'b1;
            nxt         = ST_CMD_ACK;
          end else nxt = ST_IGNORE;
        end
        ST_CMD_ACK, ST_WR_ACK: if (st.sclFall) begin
          ctl.clrAck = 1'b1;
          ctl.clrCnt = 1'b1;
          nxt        = ST_WR;
        end
        ST_WR: if (st.sclFall && st.byteDone) begin
          ctl.clrCnt = 1'b1;
          if (st.ptrWritable) begin
            ctl.wrStrobe = 1'b1;
            ctl.incPtr   = 1'b1;
            ctl.setAck   = 1'b1;
            nxt          = ST_WR_ACK;
          end else nxt = ST_IGNORE;
        end
        ST_RD: if (st.sclFall) begin
          if (st.byteDone) begin
            ctl.clrCnt = 1'b1;
            nxt        = ST_RD_ACK;
          end else ctl.shiftTx = 1'b1;
        end
        ST_RD_ACK: begin
          if (st.sclRise && !st.sdaBit) ctl.incPtr = 1'b1;
          if (st.sclFall) begin
            ctl.clrCnt = 1'b1;
            if (hostAck) begin
              ctl.loadTx = 1'b1;
              nxt        = ST_RD;
            end else nxt = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h55,
  parameter int         LAST_REG    = 107,
  parameter int         TIMEOUT_CYC = 4096,
  parameter int         FAULT_GRACE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullDn,
  output logic              sdaPullDn,
  output logic [7:0]        regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  input  logic [7:0]        regRdData,
  input  logic [LAST_REG:0] roMask,
  output logic              busFault
);
  ctlStrobe_t ctl;
  dpStatus_t  st;

  assign sclPullDn = 1'b0;

  i2cTgtControl uCtl (
    .clk  (clk),
    .rstN (rstN),
    .st   (st),
    .ctl  (ctl)
  );

  i2cTgtDatapath #(
    .TGT_ADDR    (TGT_ADDR),
    .LAST_REG    (LAST_REG),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .FAULT_GRACE (FAULT_GRACE)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ctl       (ctl),
    .roMask    (roMask),
    .regRdData (regRdData),
    .st        (st),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .sdaPullDn (sdaPullDn),
    .busFault  (busFault)
  );

endmodule

// File: rtl/i2cTgtChecker.sv
module i2cTgtChecker #(
  parameter int LAST_REG = 107
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullDn,
  input logic [7:0]        regAddr,
  input logic              regWrEn,
  input logic [LAST_REG:0] roMask,
  input logic              busFault
);
  localparam int         IDXW     = $clog2(LAST_REG + 1);
  localparam logic [7:0] LAST_PTR = 8'(LAST_REG);

  logic roHit;
  always_comb roHit = (regAddr <= LAST_PTR) ? roMask[regAddr[IDXW-1:0]] : 1'b1;

  assert_wr_writable_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !roHit);

  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_wr_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == $past(regAddr) + 8'd1));

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDn) |-> !sclIn);

  assert_fault_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    busFault |-> !sdaPullDn);

endmodule

bind i2cRegTarget i2cTgtChecker #(.LAST_REG(LAST_REG)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaPullDn (sdaPullDn),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .roMask    (roMask),
  .busFault  (busFault)
);

// File: tb/test_i2cRegTarget.sv
module test_i2cRegTarget;
  localparam int NREG = 108;
  localparam int TO   = 300;
  localparam int GR   = 8;
  localparam int H    = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic mSclDn = 1'b0, mSdaDn = 1'b0, extSdaDn = 1'b0;
  logic sclPullDn, sdaPullDn, regWrEn, busFault;
  logic [7:0] regAddr, regWrData, regRdData;
  logic [NREG-1:0] roMask = '0;
  logic sclLine, sdaLine;

  assign sclLine = !(mSclDn || sclPullDn);
  assign sdaLine = !(mSdaDn || sdaPullDn || extSdaDn);

  logic [7:0] regs [0:NREG-1];
  logic [7:0] expv [0:NREG-1];
  assign regRdData = (regAddr < 8'(NREG)) ? regs[regAddr] : 8'h00;
  always @(posedge clk) if (regWrEn && regAddr < 8'(NREG)) regs[regAddr] <= regWrData;

  i2cRegTarget #(.TIMEOUT_CYC(TO), .FAULT_GRACE(GR)) i_i2cRegTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullDn(sclPullDn), .sdaPullDn(sdaPullDn),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData), .roMask(roMask), .busFault(busFault));

  int nChecks = 0, nFail = 0, cyc = 0;
  logic done = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    mSdaDn = 1'b0; mSclDn = 1'b0; tick(H);
    mSdaDn = 1'b1; tick(H);
    mSclDn = 1'b1; tick(2);
  endtask

  task automatic busRestart;
    mSdaDn = 1'b0; tick(H);
    mSclDn = 1'b0; tick(H);
    mSdaDn = 1'b1; tick(H);
    mSclDn = 1'b1; tick(2);
  endtask

  task automatic busStop;
    mSdaDn = 1'b1; tick(H);
    mSclDn = 1'b0; tick(H);
    mSdaDn = 1'b0; tick(H);
  endtask

  task automatic sendBits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSdaDn = ~b[i]; tick(H);
      mSclDn = 1'b0;  tick(H);
      mSclDn = 1'b1;  tick(2);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output int acked);
    sendBits(b);
    mSdaDn = 1'b0; tick(H);
    mSclDn = 1'b0; tick(H/2);
    acked = sdaLine ? 0 : 1;
    tick(H/2);
    mSclDn = 1'b1; tick(2);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    mSdaDn = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      mSclDn = 1'b0; tick(H/2);
      b[i] = sdaLine;
      tick(H/2);
      mSclDn = 1'b1; tick(2);
    end
    mSdaDn = ackIt; tick(H);
    mSclDn = 1'b0;  tick(H);
    mSclDn = 1'b1;  tick(2);
    mSdaDn = 1'b0;
  endtask

  task automatic quickRead1(string tag, int exp);
    int a;
    logic [7:0] b;
    busStart; sendByte(8'hAB, a); recvByte(1'b0, b); busStop;
    chk(tag, int'(b), exp);
  endtask

  initial begin
    int a;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) begin regs[i] = 8'h00; expv[i] = 8'h00; end
    tick(3);
    chk("R10 reset sdaPullDn", int'(sdaPullDn), 0);
    chk("R10 reset busFault", int'(busFault), 0);
    rstN = 1'b1; tick(5);
    chk("R10 sclPullDn idle", int'(sclPullDn), 0);

    // R4: reset pointer is 0x00; quick read of location 0
    quickRead1("R4 quick read after reset", 0);

    // R2 sweep: fill all locations in one write
    busStart; sendByte(8'hAA, a); chk("R1 write addr ack", a, 1);
    sendByte(8'h00, a); chk("R2 cmd ack", a, 1);
    for (int i = 0; i < NREG; i++) begin
      expv[i] = 8'((i * 7 + 3) ^ (i >> 2));
      sendByte(expv[i], a); chk("R2 data ack", a, 1);
    end
    busStop;
    for (int i = 0; i < NREG; i++) chk("R2 stored", int'(regs[i]), int'(expv[i]));

    // R3 sweep: cmd 0, restart, read all, last NACK
    busStart; sendByte(8'hAA, a); sendByte(8'h00, a);
    busRestart; sendByte(8'hAB, a); chk("R3 read addr ack", a, 1);
    for (int i = 0; i < NREG; i++) begin
      recvByte(i != NREG - 1, b);
      chk("R3 read data", int'(b), int'(expv[i]));
    end
    busStop;

    // R8: pointer at 0x6B (NACK did not advance); next past end is 0xFF
    busStart; sendByte(8'hAB, a);
    recvByte(1'b1, b); chk("R8 last location", int'(b), int'(expv[NREG-1]));
    recvByte(1'b0, b); chk("R8 beyond range", int'(b), 8'hFF);
    busStop;

    // R2/R3/R5 short transfers
    busStart; sendByte(8'hAA, a); sendByte(8'h10, a);
    sendByte(8'hA5, a); sendByte(8'h3C, a); sendByte(8'h7E, a); busStop;
    expv[16] = 8'hA5; expv[17] = 8'h3C; expv[18] = 8'h7E;
    chk("R2 short write", int'(regs[17]), 8'h3C);
    busStart; sendByte(8'hAA, a); sendByte(8'h10, a);
    busRestart; sendByte(8'hAB, a);
    recvByte(1'b1, b); chk("R3 restart byte0", int'(b), 8'hA5);
    recvByte(1'b1, b); chk("R3 restart byte1", int'(b), 8'h3C);
    recvByte(1'b0, b); chk("R3 restart byte2", int'(b), 8'h7E);
    busStop;
    quickRead1("R5 host NACK no advance", 8'h7E);
    quickRead1("R4 pointer kept over STOP", 8'h7E);

    // R1: foreign address
    busStart; sendByte(8'h44, a); chk("R1 foreign addr nack", a, 0);
    sendByte(8'h05, a); chk("R1 ignored cmd", a, 0);
    sendByte(8'h99, a); chk("R1 ignored data", a, 0);
    busStop;
    chk("R1 no store", int'(regs[5]), int'(expv[5]));
    quickRead1("R1 pointer untouched", 8'h7E);

    // R6: out-of-range command
    busStart; sendByte(8'hAA, a); sendByte(8'h6C, a); chk("R6 cmd nack", a, 0);
    sendByte(8'h55, a); chk("R6 data ignored", a, 0);
    busStop;
    quickRead1("R6 pointer untouched", 8'h7E);

    // R8: write at the last location, then past the end
    busStart; sendByte(8'hAA, a); sendByte(8'h6B, a); chk("R6 cmd 0x6B ack", a, 1);
    sendByte(8'h11, a); chk("R8 last write ack", a, 1);
    sendByte(8'h22, a); chk("R8 write past end nack", a, 0);
    busStop;
    expv[107] = 8'h11;
    chk("R8 last stored", int'(regs[107]), 8'h11);

    // R7: read-only location 0x20
    roMask[32] = 1'b1;
    busStart; sendByte(8'hAA, a); sendByte(8'h1F, a);
    sendByte(8'hC1, a); chk("R7 writable ack", a, 1);
    sendByte(8'hC2, a); chk("R7 read-only nack", a, 0);
    sendByte(8'hC3, a); chk("R7 rest ignored", a, 0);
    busStop;
    expv[31] = 8'hC1;
    chk("R7 writable stored", int'(regs[31]), 8'hC1);
    chk("R7 read-only kept", int'(regs[32]), int'(expv[32]));
    chk("R7 next kept", int'(regs[33]), int'(expv[33]));
    quickRead1("R7 pointer stays at 0x20", int'(expv[32]));
    roMask[32] = 1'b0;

    // R9: external SDA stuck low
    extSdaDn = 1'b1; tick(TO + GR + 30);
    chk("R9 external stuck fault", int'(busFault), 1);
    chk("R9 no drive on fault", int'(sdaPullDn), 0);
    extSdaDn = 1'b0; tick(10);
    chk("R9 fault clears", int'(busFault), 0);

    // R9: host holds SCL low during target ACK
    busStart; sendBits(8'hAA); mSdaDn = 1'b0;
    tick(20);
    chk("R9 ack held", int'(sdaPullDn), 1);
    tick(TO - 60);
    chk("R9 not yet released", int'(sdaPullDn), 1);
    tick(80);
    chk("R9 released", int'(sdaPullDn), 0);
    chk("R9 scl stuck fault", int'(busFault), 1);
    mSclDn = 1'b0; tick(10);
    chk("R9 fault clears after scl", int'(busFault), 0);
    chk("R10 sclPullDn end", int'(sclPullDn), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule